// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block produces pulse-width modulated outputs on a small number of independent channels, by default four. A simple single-cycle register bus configures them. Every channel counts in two stages. A prescaler divides the shared input clock into ticks, and a period counter counts those ticks. The output is high for the first part of each period and low for the rest.

Software first writes a period divider and a high duration into a shadow register. It then writes the channel's control register with the update bit set. That write moves the shadowed divider, duration and prescaler into the running counters. If the channel is already producing pulses, the new settings wait for the current period to end, so no pulse is ever cut short. If the channel is idle, or is being switched off by that same write, the new settings load at once. The enable bit sits in the same control register. A disabled channel holds its counters at zero and drives its pin low.

Top module: `pwm_bank`

## Requirements
- R1: Each channel c has two 32-bit registers at byte address (2*c + r)*4. Address bit 2 selects r, and address bits 4:3 select the channel. A write to one channel changes no other channel's registers or output.
- R2: Register 0 holds the period divider in bits 15:0 and the high duration in bits 31:16, and reads back as written.
- R3: Register 1 holds the prescaler in bits 15:0, the update command in bit 30 and the enable in bit 31. It reads back the prescaler and the enable. Bit 30 and bits 29:16 always read 0.
- R4: While enabled, one output period lasts (prescaler+1)*(divider+1) clock cycles.
- R5: Each period starts with the high phase, which lasts duration*(prescaler+1) clock cycles, and ends with the low phase.
- R6: A write to either register without the update bit leaves the running timing unchanged.
- R7: An update written while the channel runs and stays enabled lets the period in progress finish with the old settings. The first period that starts after the write cycle uses the new settings, even when the write falls in the last cycle of a period.
- R8: An update written while the channel is disabled, or by the write that disables it, loads at once. An enabling write starts a fresh period from counter zero, and pwm_out rises one clock after the capturing edge.
- R9: A duration of 0 keeps the output low. A duration of divider+1 or more keeps it high.
- R10: While disabled, the counters are held at zero and the output is low from the second edge after the disabling write onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for the counters and the register bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_sel |
| pwm_out | output | NCH | One registered PWM output per channel |

## Verification
The critical collision is an update write that lands on the same clock edge as a channel's period boundary. At that edge the pending-commit path and the direct-write path both want to reload the running settings. The bench provokes this by starting the update write at each of twelve successive offsets after an observed rising edge, which sweeps the boundary cycle. At each offset it checks two things. A high phase that was already under way must still end with the old length. The next complete high phase must have the new length.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0][CW-1:0] sh_div, sh_hi, sh_pre;
  logic [NCH-1:0][CW-1:0] act_div, act_hi, act_pre;
  logic [NCH-1:0][CW-1:0] pre_cnt, per_cnt;
  logic [NCH-1:0]         en, pend;

  logic [CHW-1:0] bus_ch;
  logic           bus_r1;
  assign bus_ch = bus_addr[3 +: CHW];
  assign bus_r1 = bus_addr[2];

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit, w0, w1, upd, en_nx, at_end, run_upd, commit;
    logic [CW-1:0] div_nx, hi_nx, pre_nx;

    assign hit     = bus_sel & bus_wr & (bus_ch == CHW'(i));
    assign w0      = hit & ~bus_r1;
    assign w1      = hit & bus_r1;
    assign upd     = w1 & bus_wdata[30];
    assign en_nx   = w1 ? bus_wdata[31] : en[i];
    assign div_nx  = w0 ? bus_wdata[CW-1:0]      : sh_div[i];
    assign hi_nx   = w0 ? bus_wdata[16 +: CW]    : sh_hi[i];
    assign pre_nx  = w1 ? bus_wdata[CW-1:0]      : sh_pre[i];
    assign at_end  = (pre_cnt[i] == act_pre[i]) && (per_cnt[i] == act_div[i]);
    assign run_upd = upd & en[i] & en_nx;
    assign commit  = (upd & ~run_upd)
                   | (pend[i] & ~en_nx)
                   | (en[i] & en_nx & at_end & (pend[i] | run_upd));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_div[i]  <= '0;
        sh_hi[i]   <= '0;
        sh_pre[i]  <= '0;
        act_div[i] <= '0;
        act_hi[i]  <= '0;
        act_pre[i] <= '0;
        en[i]      <= 1'b0;
        pend[i]    <= 1'b0;
      end else begin
        sh_div[i] <= div_nx;
        sh_hi[i]  <= hi_nx;
        sh_pre[i] <= pre_nx;
        en[i]     <= en_nx;
        if (commit) begin
          act_div[i] <= div_nx;
          act_hi[i]  <= hi_nx;
          act_pre[i] <= pre_nx;
        end
        if (!en_nx || commit) pend[i] <= 1'b0;
        else if (run_upd)     pend[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre_cnt[i] <= '0;
        per_cnt[i] <= '0;
        pwm_out[i] <= 1'b0;
      end else begin
        pwm_out[i] <= en[i] & (per_cnt[i] < act_hi[i]);
        if (!en_nx || !en[i] || at_end) begin
          pre_cnt[i] <= '0;
          per_cnt[i] <= '0;
        end else if (pre_cnt[i] == act_pre[i]) begin
          pre_cnt[i] <= '0;
          per_cnt[i] <= per_cnt[i] + 1'b1;
        end else begin
          pre_cnt[i] <= pre_cnt[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (bus_sel && !bus_wr && bus_ch == CHW'(c)) begin
        if (bus_r1) bus_rdata = {en[c], 15'd0, 16'(sh_pre[c])};
        else        bus_rdata = {16'(sh_hi[c]), 16'(sh_div[c])};
      end
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [31:0]            bus_rdata,
  input logic [NCH-1:0]         pwm_out,
  input logic [NCH-1:0]         en,
  input logic [NCH-1:0][CW-1:0] act_div,
  input logic [NCH-1:0][CW-1:0] act_hi,
  input logic [NCH-1:0][CW-1:0] act_pre,
  input logic [NCH-1:0][CW-1:0] pre_cnt,
  input logic [NCH-1:0][CW-1:0] per_cnt
);
  a_r3_update_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[2]) |-> !bus_rdata[30]);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    logic last;
    assign last = (pre_cnt[i] == act_pre[i]) && (per_cnt[i] == act_div[i]);

    a_r10_idle_counters: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |-> (pre_cnt[i] == '0 && per_cnt[i] == '0));

    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !$past(en[i])) |-> !pwm_out[i]);

    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      en[i] |-> (pre_cnt[i] <= act_pre[i] && per_cnt[i] <= act_div[i]));

    a_r7_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && $past(en[i]) && !$past(last)) |->
        ($stable(act_hi[i]) && $stable(act_div[i]) && $stable(act_pre[i])));

    a_r9_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act_hi[i]) == '0) |-> !pwm_out[i]);

    a_r5_high_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en[i]) && $past(per_cnt[i]) == '0 && $past(act_hi[i]) != '0) |-> pwm_out[i]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
  .en(en), .act_div(act_div), .act_hi(act_hi), .act_pre(act_pre),
  .pre_cnt(pre_cnt), .per_cnt(per_cnt)
);

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
  localparam int NCH = 4;
  localparam int AW  = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_sel = 1'b0;
  logic           bus_wr = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  int run = 0;
  int last_len = 0;
  int n_done = 0;

  pwm_bank #(.NCH(NCH), .CW(16), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  // {prescaler, divider, duration, expected high, expected period}
  localparam logic [79:0] VEC [5] = '{
    {16'd0, 16'd9, 16'd3, 16'd3,  16'd10},
    {16'd2, 16'd4, 16'd2, 16'd6,  16'd15},
    {16'd1, 16'd7, 16'd5, 16'd10, 16'd16},
    {16'd3, 16'd2, 16'd1, 16'd4,  16'd12},
    {16'd0, 16'd1, 16'd1, 16'd1,  16'd2}
  };

  always @(negedge clk) begin
    if (!rst_n) run = 0;
    else if (pwm_out[0]) run++;
    else begin
      if (run > 0) begin last_len = run; n_done++; end
      run = 0;
    end
  end

  function automatic logic [31:0] r0(int hi, int dv);
    return {16'(hi), 16'(dv)};
  endfunction
  function automatic logic [31:0] r1(bit e, bit u, int pre);
    return {e, u, 14'd0, 16'(pre)};
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int r, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'((ch*2 + r)*4); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(int ch, int r, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'((ch*2 + r)*4);
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic measure(int ch, output int hi, output int per);
    int g = 0;
    hi = 0; per = 0;
    while (pwm_out[ch] && g < 4000) begin @(negedge clk); g++; end
    while (!pwm_out[ch] && g < 4000) begin @(negedge clk); g++; end
    while (pwm_out[ch] && g < 4000) begin hi++; @(negedge clk); g++; end
    per = hi;
    while (!pwm_out[ch] && g < 4000) begin per++; @(negedge clk); g++; end
  endtask

  task automatic hold(int ch, bit val, int n, string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch] != val) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic wait_done(int nd);
    int g = 0;
    while (n_done <= nd && g < 4000) begin @(negedge clk); g++; end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi, per, nd;
    bit was_hi;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    check(pwm_out == '0, "R10 reset output", pwm_out, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(c, 0, d); check(d == 0, "R2 reset reg0", d, 0);
      rd(c, 1, d); check(d == 0, "R3 reset reg1", d, 0);
    end

    // R1/R2 address map and field readback
    wr(2, 0, 32'h1234_5678);
    rd(2, 0, d); check(d == 32'h1234_5678, "R2 reg0 readback", d, 32'h1234_5678);
    rd(1, 0, d); check(d == 0, "R1 neighbour ch1 untouched", d, 0);
    rd(3, 0, d); check(d == 0, "R1 neighbour ch3 untouched", d, 0);
    rd(2, 1, d); check(d == 0, "R1 reg1 separate from reg0", d, 0);
    wr(1, 1, 32'hBFFF_0003);
    rd(1, 1, d); check(d == 32'h8000_0003, "R3 reserved bits read 0", d, 32'h8000_0003);
    wr(1, 1, 32'h4000_0005);
    rd(1, 1, d); check(d == 32'h0000_0005, "R3 update bit self-clears", d, 5);
    wr(2, 0, 0);

    // vector table: period and high time on rotating channels
    for (int v = 0; v < 5; v++) begin
      int ch = v % NCH;
      logic [79:0] e = VEC[v];
      wr(ch, 0, r0(int'(e[47:32]), int'(e[63:48])));
      wr(ch, 1, r1(1, 1, int'(e[79:64])));
      measure(ch, hi, per);
      check(hi == int'(e[31:16]), "R5 high time", hi, e[31:16]);
      check(per == int'(e[15:0]), "R4 period", per, e[15:0]);
      wr(ch, 1, r1(0, 0, 0));
    end

    // R1 independence: two channels running together
    wr(0, 0, r0(3, 9)); wr(0, 1, r1(1, 1, 0));
    wr(3, 0, r0(2, 4)); wr(3, 1, r1(1, 1, 2));
    measure(0, hi, per);
    check(hi == 3 && per == 10, "R1 ch0 alongside ch3", hi * 100 + per, 310);
    measure(3, hi, per);
    check(hi == 6 && per == 15, "R1 ch3 alongside ch0", hi * 100 + per, 615);
    wr(3, 1, r1(0, 0, 0));

    // R6: shadow writes without update do not change timing
    wr(0, 0, r0(7, 9));
    wr(0, 1, r1(1, 0, 4));
    measure(0, hi, per);
    check(hi == 3 && per == 10, "R6 no update no change", hi * 100 + per, 310);
    wr(0, 1, r1(1, 1, 0));
    measure(0, hi, per);
    check(hi == 7 && per == 10, "R6 update applies shadow", hi * 100 + per, 710);

    // R10: disable holds output low; R8 enable starts with high phase
    wr(0, 1, r1(0, 0, 0));
    @(negedge clk);
    hold(0, 1'b0, 50, "R10 disabled output low");
    wr(0, 0, r0(4, 9));
    wr(0, 1, r1(0, 1, 1));
    hold(0, 1'b0, 10, "R8 update while disabled keeps low");
    wr(0, 1, r1(1, 0, 1));
    begin
      int n = 0;
      @(negedge clk);
      while (pwm_out[0] && n < 100) begin n++; @(negedge clk); end
      check(n == 8, "R8 first high phase after enable", n, 8);
    end
    wr(0, 1, r1(0, 0, 0));

    // R9 constant levels
    wr(0, 0, r0(0, 9)); wr(0, 1, r1(1, 1, 1));
    hold(0, 1'b0, 40, "R9 duration zero low");
    wr(0, 1, r1(0, 0, 0));
    wr(0, 0, r0(10, 9)); wr(0, 1, r1(1, 1, 0));
    @(negedge clk);
    hold(0, 1'b1, 40, "R9 duration div+1 high");
    wr(0, 1, r1(0, 0, 0));
    wr(0, 0, r0(16'hFFFF, 9)); wr(0, 1, r1(1, 1, 2));
    @(negedge clk);
    hold(0, 1'b1, 60, "R9 duration above div high");
    wr(0, 1, r1(0, 0, 0));

    // R7: update at every offset within the period, including the boundary
    for (int k = 0; k < 12; k++) begin
      wr(0, 0, r0(6, 9));
      wr(0, 1, r1(0, 1, 0));
      wr(0, 1, r1(1, 0, 0));
      wr(0, 0, r0(2, 9));
      while (pwm_out[0]) @(negedge clk);
      while (!pwm_out[0]) @(negedge clk);
      repeat (k) @(negedge clk);
      wr(0, 1, r1(1, 1, 0));
      #1;
      was_hi = pwm_out[0];
      nd = n_done;
      if (was_hi) begin
        wait_done(nd);
        check(last_len == 6, "R7 pulse in progress kept", last_len, 6);
        nd = n_done;
      end
      wait_done(nd);
      check(last_len == 2, "R7 next period uses new setting", last_len, 2);
    end
    wr(0, 1, r1(0, 0, 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule